// File: doc/BRIEF.md
# Address-Triggered Arithmetic Coprocessor

This block is a bus slave that computes on two unsigned operands. The host never issues a command. It stores an X operand, then a Y operand, and the address used for the Y store decides which units start. The sum, the full product, the quotient and the remainder are each read back from their own location. Each unit runs independently, so an idle unit keeps its last result.

Every access is an ordinary load or store on a request/ready handshake. Stores complete with no wait state, and addition finishes within the store cycle. The multiplier takes four cycles and the restoring divider takes sixteen. A load of a product or division result that is still being computed holds `ready` low until the value is final. The host therefore needs no polling loop.

If an operand is stored while a unit is busy, that unit drops its work and restarts with the updated operands. A division by zero finishes at once with a fixed result and sets a sticky error flag.

Top module: `mmio_arith_unit`

## Requirements
- R1: After synchronous reset, the sum, product, quotient, remainder and status locations all read 0 with no wait state.
- R2: A store to word address 0x0 loads X, and a store to 0x4–0x7 loads Y. Every store completes in its first cycle (`ready` high). On a Y store, address bits [1:0] pick the units that start: 0 = adder, 1 = multiplier, 2 = divider, 3 = all three.
- R3: Address 0x8 returns (X+Y) mod 2^16, and it can be read with no wait state in the cycle right after the starting store.
- R4: Address 0x9 returns bits [15:0] of X*Y and 0xA returns bits [31:16]. A load issued right after the starting store waits exactly 4 cycles.
- R5: Address 0xB returns X/Y and 0xC returns X mod Y. A load issued right after the starting store waits exactly 16 cycles.
- R6: A division with Y = 0 finishes with no wait state. The quotient reads 0xFFFF and the remainder reads X.
- R7: Status address 0xD bit 0 is set by a division by zero. It stays set, including across later valid divisions, until reset.
- R8: An operand store (X or Y) while the multiplier or divider is busy restarts that unit with the updated operands. The adder changes only on a Y store that selects it.
- R9: A Y store that does not select a unit leaves that unit's result unchanged.
- R10: Stores to result or status addresses have no effect. Loads of 0x0–0x7, 0xE and 0xF return 0 with no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, held until accepted |
| we | input | 1 | 1 = store, 0 = load |
| addr | input | 4 | Word address |
| wdata | input | 16 | Store data |
| rdata | output | 16 | Load data, valid while `req` and `ready` are high |
| ready | output | 1 | Access completes on the clock edge where `req` and `ready` are both high |

## Verification
The assertions assume the host holds `addr`, `we` and `wdata` stable while `req` is high and `ready` is low. They also assume no access is treated as complete before `ready` is seen high. The bench drives each access on the falling edge and keeps it unchanged until it observes `ready`. It then presents the next access on the following falling edge, so back-to-back loads fall exactly in the stall windows.

// File: rtl/mau_pkg.sv
package mau_pkg;

    localparam int unsigned MAU_ADDR_W = 4;

    // Word address map; Y stores occupy 0x4..0x7 with bits [1:0] as the unit select
    typedef enum logic [MAU_ADDR_W-1:0] {
        LOC_X      = 4'h0,
        LOC_Y_ADD  = 4'h4,
        LOC_Y_MUL  = 4'h5,
        LOC_Y_DIV  = 4'h6,
        LOC_Y_ALL  = 4'h7,
        LOC_SUM    = 4'h8,
        LOC_PROD_L = 4'h9,
        LOC_PROD_H = 4'hA,
        LOC_QUOT   = 4'hB,
        LOC_REMN   = 4'hC,
        LOC_STAT   = 4'hD
    } loc_e;

    typedef enum logic [1:0] {
        UNIT_ADD = 2'd0,
        UNIT_MUL = 2'd1,
        UNIT_DIV = 2'd2,
        UNIT_ALL = 2'd3
    } unit_sel_e;

    typedef struct packed {
        logic ld_x;
        logic ld_y;
        logic sel_add;
        logic sel_mul;
        logic sel_div;
    } store_dec_t;

    function automatic store_dec_t decode_store(input logic wr, input logic [MAU_ADDR_W-1:0] a);
        store_dec_t d;
        unit_sel_e  u;
        u         = unit_sel_e'(a[1:0]);
        d.ld_x    = wr && (a == LOC_X);
        d.ld_y    = wr && (a[MAU_ADDR_W-1:2] == 2'b01);
        d.sel_add = d.ld_y && (u == UNIT_ADD || u == UNIT_ALL);
        d.sel_mul = d.ld_y && (u == UNIT_MUL || u == UNIT_ALL);
        d.sel_div = d.ld_y && (u == UNIT_DIV || u == UNIT_ALL);
        return d;
    endfunction

endpackage

// File: rtl/mau_mul.sv
module mau_mul #(
    parameter int unsigned W     = 16,
    parameter int unsigned DIGIT = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           busy,
    output logic [2*W-1:0] prod
);
    localparam int unsigned STEPS = W / DIGIT;
    localparam int unsigned CW    = (STEPS > 1) ? $clog2(STEPS) : 1;

    logic [W-1:0]   mcand;
    logic [W-1:0]   mplier;
    logic [2*W-1:0] acc;
    logic [CW-1:0]  cnt;
    logic [2*W-1:0] pp;
    logic [2*W-1:0] pp_sh;

    // One radix-2^DIGIT partial product per cycle, aligned to its digit position
    always_comb begin
        pp    = {{W{1'b0}}, mcand} * {{(2*W-DIGIT){1'b0}}, mplier[DIGIT-1:0]};
        pp_sh = pp << (DIGIT * cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand  <= '0;
            mplier <= '0;
            acc    <= '0;
            cnt    <= '0;
            busy   <= 1'b0;
        end else if (start) begin
            mcand  <= a;
            mplier <= b;
            acc    <= '0;
            cnt    <= '0;
            busy   <= 1'b1;
        end else if (busy) begin
            acc    <= acc + pp_sh;
            mplier <= mplier >> DIGIT;
            cnt    <= cnt + CW'(1);
            if (cnt == CW'(STEPS - 1)) busy <= 1'b0;
        end
    end

    assign prod = acc;

    a_r4_mul_starts: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);
    a_r4_mul_last_step: assert property (@(posedge clk) disable iff (rst)
        busy && !start && cnt == CW'(STEPS - 1) |=> !busy);
    a_r9_mul_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !busy && !start |=> $stable(acc));

endmodule

// File: rtl/mau_div.sv
module mau_div #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         zero_div,
    output logic [W-1:0] quot,
    output logic [W-1:0] remn
);
    localparam int unsigned CW = $clog2(W);

    logic [W-1:0]  q;
    logic [W-1:0]  r;
    logic [W-1:0]  d;
    logic [CW-1:0] cnt;
    logic [W:0]    trial;
    logic [W:0]    diff;

    assign zero_div = start && (divisor == '0);

    // Restoring step: shift in the next dividend bit, keep the difference if non-negative
    always_comb begin
        trial = {r, q[W-1]};
        diff  = trial - {1'b0, d};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            r    <= '0;
            d    <= '0;
            cnt  <= '0;
            busy <= 1'b0;
        end else if (start) begin
            if (divisor == '0) begin
                q    <= '1;
                r    <= dividend;
                busy <= 1'b0;
            end else begin
                q    <= dividend;
                r    <= '0;
                d    <= divisor;
                cnt  <= '0;
                busy <= 1'b1;
            end
        end else if (busy) begin
            if (!diff[W]) begin
                r <= diff[W-1:0];
                q <= {q[W-2:0], 1'b1};
            end else begin
                r <= trial[W-1:0];
                q <= {q[W-2:0], 1'b0};
            end
            cnt <= cnt + CW'(1);
            if (cnt == CW'(W - 1)) busy <= 1'b0;
        end
    end

    assign quot = q;
    assign remn = r;

    a_r5_div_starts: assert property (@(posedge clk) disable iff (rst)
        start && divisor != '0 |=> busy);
    a_r6_div_zero_result: assert property (@(posedge clk) disable iff (rst)
        start && divisor == '0 |=> !busy && q == '1 && r == $past(dividend));
    a_r5_div_last_step: assert property (@(posedge clk) disable iff (rst)
        busy && !start && cnt == CW'(W - 1) |=> !busy);

endmodule

// File: rtl/mmio_arith_unit.sv
module mmio_arith_unit
    import mau_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned MUL_DIGIT = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req,
    input  logic                  we,
    input  logic [MAU_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output logic                  ready
);
    logic              xfer;
    store_dec_t        dec;
    logic              opnd_wr;
    logic [DATA_W-1:0] x_q, y_q, x_nx, y_nx;
    logic [DATA_W-1:0] sum_q;
    logic              err_q;
    logic              go_add, go_mul, go_div;

    logic                mul_busy;
    logic [2*DATA_W-1:0] prod;
    logic                div_busy, div_zero;
    logic [DATA_W-1:0]   quot, remn;

    assign xfer    = req && ready;
    assign dec     = decode_store(xfer && we, addr);
    assign opnd_wr = dec.ld_x || dec.ld_y;
    assign x_nx    = dec.ld_x ? wdata : x_q;
    assign y_nx    = dec.ld_y ? wdata : y_q;

    // Selected units start; a busy unit restarts on any operand store
    assign go_add = dec.sel_add;
    assign go_mul = dec.sel_mul || (opnd_wr && mul_busy);
    assign go_div = dec.sel_div || (opnd_wr && div_busy);

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q   <= '0;
            y_q   <= '0;
            sum_q <= '0;
            err_q <= 1'b0;
        end else begin
            x_q <= x_nx;
            y_q <= y_nx;
            if (go_add)   sum_q <= x_nx + y_nx;
            if (div_zero) err_q <= 1'b1;
        end
    end

    mau_mul #(.W(DATA_W), .DIGIT(MUL_DIGIT)) u_mul (
        .clk(clk), .rst(rst), .start(go_mul),
        .a(x_nx), .b(y_nx), .busy(mul_busy), .prod(prod)
    );

    mau_div #(.W(DATA_W)) u_div (
        .clk(clk), .rst(rst), .start(go_div),
        .dividend(x_nx), .divisor(y_nx), .busy(div_busy),
        .zero_div(div_zero), .quot(quot), .remn(remn)
    );

    // Wait states: only loads of an unfinished result are held off
    always_comb begin
        ready = 1'b1;
        if (req && !we) begin
            case (addr)
                LOC_PROD_L, LOC_PROD_H: ready = !mul_busy;
                LOC_QUOT,   LOC_REMN:   ready = !div_busy;
                default:                ready = 1'b1;
            endcase
        end
    end

    always_comb begin
        case (addr)
            LOC_SUM:    rdata = sum_q;
            LOC_PROD_L: rdata = prod[DATA_W-1:0];
            LOC_PROD_H: rdata = prod[2*DATA_W-1:DATA_W];
            LOC_QUOT:   rdata = quot;
            LOC_REMN:   rdata = remn;
            LOC_STAT:   rdata = {{(DATA_W-1){1'b0}}, err_q};
            default:    rdata = '0;
        endcase
    end

    a_r2_store_no_wait: assert property (@(posedge clk) disable iff (rst)
        req && we |-> ready);
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);
    a_r9_sum_hold: assert property (@(posedge clk) disable iff (rst)
        !go_add |=> $stable(sum_q));
    a_r8_restart_mul: assert property (@(posedge clk) disable iff (rst)
        xfer && we && (dec.ld_x || dec.ld_y) && mul_busy |=> mul_busy);
    a_r6_zero_div_no_busy: assert property (@(posedge clk) disable iff (rst)
        div_zero |=> !div_busy);

endmodule

// File: tb/mmio_arith_unit_test.sv
module mmio_arith_unit_test;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic          we  = 1'b0;
    logic [3:0]    addr = '0;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  rdata;
    logic          ready;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;   // 250 MHz

    mmio_arith_unit #(.DATA_W(W), .MUL_DIGIT(4)) uut (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ready(ready)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_ready(output int waits);
        waits = 0;
        #1;
        while (!ready) begin
            @(negedge clk);
            #1;
            waits++;
            if (waits > 2000) begin
                n_chk++; n_fail++;
                $display("FAIL bus: actual stall >2000 expected completion");
                break;
            end
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [W-1:0] d, output int waits);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        wait_ready(waits);
        @(posedge clk);
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [W-1:0] d, output int waits);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a; wdata = '0;
        wait_ready(waits);
        d = rdata;
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [W-1:0] d; int w;
        for (int a = 8; a <= 13; a++) begin
            bus_rd(4'(a), d, w);
            check("R1 value", 32'(d), 32'h0);
            check("R1 waits", 32'(w), 32'd0);
        end
        idle();
    endtask

    task automatic t_add(input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W-1:0] d; int w;
        bus_wr(4'h0, x, w);
        check("R2 X store waits", 32'(w), 32'd0);
        bus_wr(4'h4, y, w);
        check("R2 Y store waits", 32'(w), 32'd0);
        bus_rd(4'h8, d, w);
        check("R3 sum", 32'(d), 32'(W'(x + y)));
        check("R3 sum waits", 32'(w), 32'd0);
        idle();
    endtask

    task automatic t_mul(input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W-1:0] lo, hi; int w, w2; logic [31:0] p;
        p = 32'(x) * 32'(y);
        bus_wr(4'h0, x, w);
        bus_wr(4'h5, y, w);
        bus_rd(4'h9, lo, w);
        bus_rd(4'hA, hi, w2);
        check("R4 product low", 32'(lo), 32'(p[15:0]));
        check("R4 product high", 32'(hi), 32'(p[31:16]));
        check("R4 stall cycles", 32'(w), 32'd4);
        idle();
    endtask

    task automatic t_div(input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W-1:0] q, r; int w, w2;
        bus_wr(4'h0, x, w);
        bus_wr(4'h6, y, w);
        bus_rd(4'hB, q, w);
        bus_rd(4'hC, r, w2);
        check("R5 quotient", 32'(q), 32'(x / y));
        check("R5 remainder", 32'(r), 32'(x % y));
        check("R5 stall cycles", 32'(w), 32'd16);
        idle();
    endtask

    task automatic t_div_zero();
        logic [W-1:0] d; int w;
        bus_wr(4'h0, 16'h1234, w);
        bus_wr(4'h6, 16'h0000, w);
        bus_rd(4'hB, d, w);
        check("R6 quotient", 32'(d), 32'hFFFF);
        check("R6 waits", 32'(w), 32'd0);
        bus_rd(4'hC, d, w);
        check("R6 remainder", 32'(d), 32'h1234);
        bus_rd(4'hD, d, w);
        check("R7 status set", 32'(d), 32'h1);
        bus_wr(4'h0, 16'd100, w);
        bus_wr(4'h6, 16'd10, w);
        bus_rd(4'hB, d, w);
        check("R7 later quotient", 32'(d), 32'd10);
        bus_rd(4'hD, d, w);
        check("R7 status sticky", 32'(d), 32'h1);
        idle();
    endtask

    task automatic t_isolation();
        logic [W-1:0] d; int w;
        bus_wr(4'h0, 16'd3, w);
        bus_wr(4'h7, 16'd4, w);
        bus_rd(4'hB, d, w);       // let the divider finish
        bus_wr(4'h0, 16'd10, w);
        bus_wr(4'h5, 16'd20, w);  // multiplier only
        bus_rd(4'h9, d, w);
        check("R9 product", 32'(d), 32'd200);
        bus_rd(4'h8, d, w);
        check("R9 sum unchanged", 32'(d), 32'd7);
        bus_rd(4'hB, d, w);
        check("R9 quotient unchanged", 32'(d), 32'd0);
        bus_rd(4'hC, d, w);
        check("R9 remainder unchanged", 32'(d), 32'd3);
        idle();
    endtask

    task automatic t_abort();
        logic [W-1:0] d; int w;
        bus_wr(4'h0, 16'd100, w);
        bus_wr(4'h7, 16'd3, w);
        bus_wr(4'h0, 16'd7, w);   // mid-flight X store restarts mul and div
        bus_rd(4'h9, d, w);
        check("R8 restarted product", 32'(d), 32'd21);
        check("R8 restart stall", 32'(w), 32'd4);
        bus_rd(4'hB, d, w);
        check("R8 restarted quotient", 32'(d), 32'd2);
        bus_rd(4'hC, d, w);
        check("R8 restarted remainder", 32'(d), 32'd1);
        bus_rd(4'h8, d, w);
        check("R8 sum from Y store", 32'(d), 32'd103);
        idle();
    endtask

    task automatic t_ignored();
        logic [W-1:0] d; int w;
        bus_wr(4'h0, 16'h0011, w);
        bus_wr(4'h4, 16'h0022, w);
        bus_wr(4'h8, 16'hBEEF, w);
        bus_wr(4'hD, 16'hFFFF, w);
        bus_rd(4'h8, d, w);
        check("R10 sum after stray store", 32'(d), 32'h33);
        bus_rd(4'h0, d, w);
        check("R10 X location reads zero", 32'(d), 32'h0);
        bus_rd(4'h5, d, w);
        check("R10 Y location reads zero", 32'(d), 32'h0);
        bus_rd(4'hE, d, w);
        check("R10 unmapped reads zero", 32'(d), 32'h0);
        check("R10 unmapped waits", 32'(w), 32'd0);
        idle();
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_add(16'h1234, 16'h4321);
        t_add(16'hFFFF, 16'h0002);
        t_mul(16'h1234, 16'h5678);
        t_mul(16'hFFFF, 16'hFFFF);
        t_mul(16'h0000, 16'hABCD);
        t_div(16'd1000, 16'd7);
        t_div(16'hFFFF, 16'd1);
        t_div(16'd5, 16'd9);
        t_div(16'hFFFF, 16'hFFFF);
        t_div_zero();
        t_isolation();
        t_abort();
        t_ignored();
        do_reset();
        t_reset_state();   // R1, R7: reset clears the sticky flag
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule